// File: doc/BRIEF.md
# Port Controller Reset Command Logic

This block is the write-only command register of a four-port power-sourcing controller. A host write to the command address starts one-shot actions: clear every event and the interrupt summary, release the interrupt pin alone, return the whole controller to its power-up state, or force chosen ports off. Each action becomes a single-cycle strobe. The strobes drive the clear logic of the per-port event, status, enable and fault storage, and send an off request to each port state machine. That off request also ends any cool-down period on the port.

The block holds model registers for the state these commands touch. For each port these are the event and fault bits, the status field, the detect and class enables, and the power-enable and power-good state with their change flags. It also holds two supply undervoltage flags and the interrupt pin logic. The serial bus engine writes the command byte through `host_wr`, `host_addr` and `host_wdata`. The other inputs stand in for the detection, classification and power-switching logic that load this state. The register has no read path, so it always reads back as zero.

Top module: `pse_cmd_reset`

## Requirements
- R1: A command acts only when `host_wr` is high and `host_addr` equals CMD_ADDR (default 0x1A). With any other address, or with `host_wr` low, no strobe is produced.
- R2: Every data bit written as 1 gives a strobe lasting exactly one cycle, in the cycle after the write edge. Bit 7 drives `cmd_clr_all`, bit 6 drives `cmd_pin_rel`, bit 4 drives `cmd_soft_rst`, and bit n (n < NPORT) drives `port_off[n]`. Bits written as 0, and bit 5, give no strobe.
- R3: One cycle after `cmd_clr_all`, the following are all zero: every event bit of every port, `pec_q`, `pgc_q`, `sup_uv_q` and `int_sum`. At the same point `int_n` is high.
- R4: One cycle after `cmd_pin_rel`, `int_n` is high, while `evt_q` and `int_sum` keep their values.
- R5: A released pin asserts again (`int_n` low) one cycle after any event bit goes from 0 to 1 in a category that `int_mask` enables. A bit that becomes newly set in a masked category leaves the pin released.
- R6: One cycle after `cmd_soft_rst`, all model state is back at its reset value. The exception is `sup_uv_q`, which takes the live `uv_live` value. The release state is cleared too, so a live supply flag that is unmasked drives `int_n` low.
- R7: One cycle after `port_off[n]`, port n has the following cleared: all seven event bits, its status field, both enable bits, `pe_q[n]` and `pg_q[n]`. The other ports are unchanged.
- R8: `pwr_on_req[n]` sets `pe_q[n]`, and `pg_q[n]` is registered as the next `pe_q[n]` AND `pg_live[n]`. Any change of `pe_q[n]` sets `pec_q[n]`, and any change of `pg_q[n]` sets `pgc_q[n]`. This includes a turn-off by port reset. A port reset of a port that is already off sets neither flag.
- R9: A port reset overrides `pwr_on_req` only on the edge where it acts. A request in the next cycle powers the port again, because no cool-down delay remains.
- R10: When one write sets both bit 7 and port reset bits, the clear-all wins: `pec_q` and `pgc_q` read zero afterwards.
- R11: `evt_set` bits are sticky. Port n uses `evt_q[n*7 +: 7]`, with bit 0 class, bit 1 detect, bit 2 disconnect, bit 3 overcurrent, bit 4 start, bit 5 current-limit and bit 6 power-on fault. `int_n` is low exactly when `int_sum & int_mask` is nonzero and the pin is not released.
- R12: `int_sum` has five category bits, each set when any port has a bit of that category set:
  - bit 0: power change (`pec`/`pgc`)
  - bit 1: class/detect
  - bit 2: disconnect, overcurrent or power-on fault
  - bit 3: start/current-limit
  - bit 4: any supply flag

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data byte |
| evt_set | input | NPORT*7 | Per-port event set pulses |
| stat_we | input | NPORT | Per-port status load enable |
| stat_wdata | input | STW | Status value to load |
| dcen_we | input | NPORT | Per-port detect/class enable load |
| dcen_wdata | input | 2 | Enable value (bit 0 detect, bit 1 class) |
| pwr_on_req | input | NPORT | Per-port power-on request |
| pg_live | input | NPORT | Live power-good indication |
| uv_live | input | 2 | Live undervoltage status of logic and power rails |
| int_mask | input | 5 | Interrupt category enables |
| cmd_clr_all | output | 1 | Clear-all strobe |
| cmd_pin_rel | output | 1 | Pin-release strobe |
| cmd_soft_rst | output | 1 | Full soft reset strobe |
| port_off | output | NPORT | Per-port forced-off and cool-down abort strobe |
| evt_q | output | NPORT*7 | Per-port event bits |
| stat_q | output | NPORT*STW | Per-port status fields |
| dcen_q | output | 2*NPORT | Per-port detect/class enables |
| pe_q | output | NPORT | Power-enable state |
| pg_q | output | NPORT | Power-good state |
| pec_q | output | NPORT | Power-enable change flags |
| pgc_q | output | NPORT | Power-good change flags |
| sup_uv_q | output | 2 | Supply undervoltage flags |
| int_sum | output | 5 | Interrupt category summary |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
Command strobes appear one clock after the write edge. Model state moves one clock after the strobe. A change in the pin that follows a new event comes one clock after that event bit is stored. The bench drives every input on a falling edge. Its write task samples the strobes on the falling edge between the two rising edges, then returns after the second rising edge, so every state check falls on the cycle where its result is due. The event task waits one extra cycle, so that checks of the pin's re-assertion land after the release flag has been updated.

// File: rtl/pse_rst_pkg.sv
`timescale 1ns/1ps
// Shared field positions, categories and strobe type for the reset command block.
package pse_rst_pkg;

  // Command byte bit positions: the host software depends on these.
  localparam int CMD_BIT_CLR_ALL = 7;
  localparam int CMD_BIT_PIN_REL = 6;
  localparam int CMD_BIT_SOFT    = 4;

  // Per-port event bit layout
  localparam int EV_CLS  = 0;
  localparam int EV_DET  = 1;
  localparam int EV_DISF = 2;
  localparam int EV_ICUT = 3;
  localparam int EV_STRT = 4;
  localparam int EV_ILIM = 5;
  localparam int EV_POF  = 6;
  localparam int EVW     = 7;

  // Interrupt summary categories
  localparam int CAT_PWR  = 0;
  localparam int CAT_DET  = 1;
  localparam int CAT_FLT  = 2;
  localparam int CAT_STRT = 3;
  localparam int CAT_SUP  = 4;
  localparam int NPCAT    = 4;  // categories owned by ports
  localparam int NCAT     = 5;  // plus supply

  typedef struct packed {
    logic clr_all;
    logic pin_rel;
    logic soft_rst;
  } cmd_glob_t;

  function automatic logic [NPCAT-1:0] group_cat(input logic [EVW-1:0] ev,
                                                 input logic pec,
                                                 input logic pgc);
    logic [NPCAT-1:0] c;
    c[CAT_PWR]  = pec | pgc;
    c[CAT_DET]  = ev[EV_CLS] | ev[EV_DET];
    c[CAT_FLT]  = ev[EV_DISF] | ev[EV_ICUT] | ev[EV_POF];
    c[CAT_STRT] = ev[EV_STRT] | ev[EV_ILIM];
    return c;
  endfunction

endpackage

// File: rtl/pse_cmd_decode.sv
`timescale 1ns/1ps
// Address decode of the command byte and one-cycle action strobes.
module pse_cmd_decode
  import pse_rst_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int NPORT = 4,
  parameter logic [AW-1:0] CMD_ADDR = AW'(8'h1A)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output cmd_glob_t        glob_q,
  output logic [NPORT-1:0] off_q
);

  logic             hit;
  cmd_glob_t        glob_nx;
  logic [NPORT-1:0] off_nx;
  logic             unused_wbits;

  // The reserved bit 5 and any data bits above the port field feed nothing.
  assign unused_wbits = ^host_wdata;

  always_comb begin
    hit     = host_wr && (host_addr == CMD_ADDR);
    glob_nx = '0;
    off_nx  = '0;
    if (hit) begin
      glob_nx.clr_all  = host_wdata[CMD_BIT_CLR_ALL];
      glob_nx.pin_rel  = host_wdata[CMD_BIT_PIN_REL];
      glob_nx.soft_rst = host_wdata[CMD_BIT_SOFT];
      off_nx           = host_wdata[NPORT-1:0];
    end
  end

  // Strobes fall back to zero by themselves: bits self-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
      off_q  <= '0;
    end else begin
      glob_q <= glob_nx;
      off_q  <= off_nx;
    end
  end

endmodule

// File: rtl/pse_port_slot.sv
`timescale 1ns/1ps
// Per-port model of the state that the reset commands touch.
module pse_port_slot
  import pse_rst_pkg::*;
#(
  parameter int STW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_glob_t        glob,
  input  logic             port_off,
  input  logic [EVW-1:0]   evt_set,
  input  logic             stat_we,
  input  logic [STW-1:0]   stat_wdata,
  input  logic             dcen_we,
  input  logic [1:0]       dcen_wdata,
  input  logic             pwr_on_req,
  input  logic             pg_live,
  output logic [EVW-1:0]   evt_q,
  output logic [STW-1:0]   stat_q,
  output logic [1:0]       dcen_q,
  output logic             pe_q,
  output logic             pg_q,
  output logic             pec_q,
  output logic             pgc_q,
  output logic [NPCAT-1:0] cat_o,
  output logic [NPCAT-1:0] rise_q
);

  logic [EVW-1:0]   evt_nx;
  logic [STW-1:0]   stat_nx;
  logic [1:0]       dcen_nx;
  logic             pe_nx, pg_nx, pec_nx, pgc_nx;
  logic [NPCAT-1:0] rise_nx;

  // Ordering of the overrides: port reset, then clear-all, then soft reset.
  always_comb begin
    evt_nx  = evt_q | evt_set;
    stat_nx = stat_we ? stat_wdata : stat_q;
    dcen_nx = dcen_we ? dcen_wdata : dcen_q;
    pe_nx   = pwr_on_req ? 1'b1 : pe_q;
    if (port_off) begin
      evt_nx  = '0;
      stat_nx = '0;
      dcen_nx = '0;
      pe_nx   = 1'b0;   // no cool-down: a request next cycle wins again
    end
    pg_nx  = pe_nx & pg_live;
    pec_nx = pec_q | (pe_nx ^ pe_q);
    pgc_nx = pgc_q | (pg_nx ^ pg_q);
    if (glob.clr_all) begin
      evt_nx = '0;
      pec_nx = 1'b0;
      pgc_nx = 1'b0;
    end
    if (glob.soft_rst) begin
      evt_nx  = '0;
      stat_nx = '0;
      dcen_nx = '0;
      pe_nx   = 1'b0;
      pg_nx   = 1'b0;
      pec_nx  = 1'b0;
      pgc_nx  = 1'b0;
    end
    rise_nx = group_cat(evt_nx & ~evt_q, pec_nx & ~pec_q, pgc_nx & ~pgc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      stat_q <= '0;
      dcen_q <= '0;
      pe_q   <= 1'b0;
      pg_q   <= 1'b0;
      pec_q  <= 1'b0;
      pgc_q  <= 1'b0;
      rise_q <= '0;
    end else begin
      evt_q  <= evt_nx;
      stat_q <= stat_nx;
      dcen_q <= dcen_nx;
      pe_q   <= pe_nx;
      pg_q   <= pg_nx;
      pec_q  <= pec_nx;
      pgc_q  <= pgc_nx;
      rise_q <= rise_nx;
    end
  end

  assign cat_o = group_cat(evt_q, pec_q, pgc_q);

endmodule

// File: rtl/pse_irq_ctrl.sv
`timescale 1ns/1ps
// Supply flags, interrupt summary and pin release tracking.
module pse_irq_ctrl
  import pse_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_glob_t        glob,
  input  logic [NPCAT-1:0] port_cat,
  input  logic [NPCAT-1:0] port_rise,
  input  logic [NCAT-1:0]  int_mask,
  input  logic [1:0]       uv_live,
  output logic [1:0]       sup_q,
  output logic [NCAT-1:0]  int_sum,
  output logic             int_n
);

  logic [1:0]      sup_nx;
  logic            sup_rise_nx, sup_rise_q;
  logic            rel_nx, rel_q;
  logic [NCAT-1:0] rise_all;

  assign rise_all = {sup_rise_q, port_rise};

  always_comb begin
    sup_nx = sup_q | uv_live;
    if (glob.clr_all)  sup_nx = '0;
    if (glob.soft_rst) sup_nx = uv_live;   // supply flags track the rails
    sup_rise_nx = |(sup_nx & ~sup_q);

    rel_nx = rel_q;
    if (|(rise_all & int_mask))         rel_nx = 1'b0;
    if (glob.clr_all || glob.pin_rel)   rel_nx = 1'b1;
    if (glob.soft_rst)                  rel_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q      <= '0;
      sup_rise_q <= 1'b0;
      rel_q      <= 1'b0;
    end else begin
      sup_q      <= sup_nx;
      sup_rise_q <= sup_rise_nx;
      rel_q      <= rel_nx;
    end
  end

  assign int_sum = {|sup_q, port_cat};
  assign int_n   = ~((|(int_sum & int_mask)) & ~rel_q);

endmodule

// File: rtl/pse_cmd_reset.sv
`timescale 1ns/1ps
// Reset command register with per-port clear fan-out and interrupt pin control.
module pse_cmd_reset
  import pse_rst_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int NPORT = 4,   // port bits sit below the soft reset bit: at most 4
  parameter int STW   = 7,
  parameter logic [AW-1:0] CMD_ADDR = AW'(8'h1A)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  input  logic [NPORT*EVW-1:0]   evt_set,
  input  logic [NPORT-1:0]       stat_we,
  input  logic [STW-1:0]         stat_wdata,
  input  logic [NPORT-1:0]       dcen_we,
  input  logic [1:0]             dcen_wdata,
  input  logic [NPORT-1:0]       pwr_on_req,
  input  logic [NPORT-1:0]       pg_live,
  input  logic [1:0]             uv_live,
  input  logic [NCAT-1:0]        int_mask,
  output logic                   cmd_clr_all,
  output logic                   cmd_pin_rel,
  output logic                   cmd_soft_rst,
  output logic [NPORT-1:0]       port_off,
  output logic [NPORT*EVW-1:0]   evt_q,
  output logic [NPORT*STW-1:0]   stat_q,
  output logic [2*NPORT-1:0]     dcen_q,
  output logic [NPORT-1:0]       pe_q,
  output logic [NPORT-1:0]       pg_q,
  output logic [NPORT-1:0]       pec_q,
  output logic [NPORT-1:0]       pgc_q,
  output logic [1:0]             sup_uv_q,
  output logic [NCAT-1:0]        int_sum,
  output logic                   int_n
);

  cmd_glob_t        glob_q;
  logic [NPORT-1:0] off_q;
  logic [NPCAT-1:0] cat_p  [NPORT];
  logic [NPCAT-1:0] rise_p [NPORT];
  logic [NPCAT-1:0] cat_any, rise_any;

  pse_cmd_decode #(
    .AW(AW), .DW(DW), .NPORT(NPORT), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .glob_q     (glob_q),
    .off_q      (off_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pse_port_slot #(.STW(STW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .glob       (glob_q),
      .port_off   (off_q[p]),
      .evt_set    (evt_set[p*EVW +: EVW]),
      .stat_we    (stat_we[p]),
      .stat_wdata (stat_wdata),
      .dcen_we    (dcen_we[p]),
      .dcen_wdata (dcen_wdata),
      .pwr_on_req (pwr_on_req[p]),
      .pg_live    (pg_live[p]),
      .evt_q      (evt_q[p*EVW +: EVW]),
      .stat_q     (stat_q[p*STW +: STW]),
      .dcen_q     (dcen_q[p*2 +: 2]),
      .pe_q       (pe_q[p]),
      .pg_q       (pg_q[p]),
      .pec_q      (pec_q[p]),
      .pgc_q      (pgc_q[p]),
      .cat_o      (cat_p[p]),
      .rise_q     (rise_p[p])
    );
  end

  always_comb begin
    cat_any  = '0;
    rise_any = '0;
    for (int p = 0; p < NPORT; p++) begin
      cat_any  = cat_any  | cat_p[p];
      rise_any = rise_any | rise_p[p];
    end
  end

  pse_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob      (glob_q),
    .port_cat  (cat_any),
    .port_rise (rise_any),
    .int_mask  (int_mask),
    .uv_live   (uv_live),
    .sup_q     (sup_uv_q),
    .int_sum   (int_sum),
    .int_n     (int_n)
  );

  assign cmd_clr_all  = glob_q.clr_all;
  assign cmd_pin_rel  = glob_q.pin_rel;
  assign cmd_soft_rst = glob_q.soft_rst;
  assign port_off     = off_q;

endmodule

// File: rtl/pse_cmd_reset_chk.sv
`timescale 1ns/1ps
// Property checker, attached to the top by bind.
module pse_cmd_reset_chk
  import pse_rst_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NPORT = 4,
  parameter logic [AW-1:0] CMD_ADDR = AW'(8'h1A)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_wr,
  input logic [AW-1:0]        host_addr,
  input cmd_glob_t            glob,
  input logic [NPORT-1:0]     port_off,
  input logic [NPORT*EVW-1:0] evt_q,
  input logic [NPORT-1:0]     pe_q,
  input logic [NPORT-1:0]     pec_q,
  input logic [NPORT-1:0]     pgc_q,
  input logic [1:0]           sup_q,
  input logic [1:0]           uv_live,
  input logic [NCAT-1:0]      int_sum,
  input logic [NCAT-1:0]      int_mask,
  input logic                 int_n
);

  p_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((glob != '0) || (port_off != '0)) |-> $past(host_wr && (host_addr == CMD_ADDR)));

  p_clr_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (glob.clr_all && !glob.soft_rst) |=>
      (evt_q == '0 && pec_q == '0 && pgc_q == '0 && sup_q == 2'b00 && int_n));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob.pin_rel && !glob.soft_rst) |=> int_n);

  p_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    glob.soft_rst |=> (pe_q == '0 && evt_q == '0 && pec_q == '0 && sup_q == $past(uv_live)));

  p_port_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off != '0) |=> ((pe_q & $past(port_off)) == '0));

  p_pin_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> ((int_sum & int_mask) != '0));

endmodule

bind pse_cmd_reset pse_cmd_reset_chk #(
  .AW(AW), .NPORT(NPORT), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .glob      (glob_q),
  .port_off  (off_q),
  .evt_q     (evt_q),
  .pe_q      (pe_q),
  .pec_q     (pec_q),
  .pgc_q     (pgc_q),
  .sup_q     (sup_uv_q),
  .uv_live   (uv_live),
  .int_sum   (int_sum),
  .int_mask  (int_mask),
  .int_n     (int_n)
);

// File: tb/test_pse_cmd_reset.sv
`timescale 1ns/1ps
module test_pse_cmd_reset;
  import pse_rst_pkg::*;

  localparam int NPORT = 4;
  localparam int STW   = 7;

  logic                 clk;
  logic                 rst_n;
  logic                 host_wr;
  logic [7:0]           host_addr;
  logic [7:0]           host_wdata;
  logic [NPORT*EVW-1:0] evt_set;
  logic [NPORT-1:0]     stat_we;
  logic [STW-1:0]       stat_wdata;
  logic [NPORT-1:0]     dcen_we;
  logic [1:0]           dcen_wdata;
  logic [NPORT-1:0]     pwr_on_req;
  logic [NPORT-1:0]     pg_live;
  logic [1:0]           uv_live;
  logic [NCAT-1:0]      int_mask;
  logic                 cmd_clr_all, cmd_pin_rel, cmd_soft_rst;
  logic [NPORT-1:0]     port_off;
  logic [NPORT*EVW-1:0] evt_q;
  logic [NPORT*STW-1:0] stat_q;
  logic [2*NPORT-1:0]   dcen_q;
  logic [NPORT-1:0]     pe_q, pg_q, pec_q, pgc_q;
  logic [1:0]           sup_uv_q;
  logic [NCAT-1:0]      int_sum;
  logic                 int_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pse_cmd_reset i_pse_cmd_reset (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .evt_set(evt_set), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .dcen_we(dcen_we), .dcen_wdata(dcen_wdata),
    .pwr_on_req(pwr_on_req), .pg_live(pg_live), .uv_live(uv_live),
    .int_mask(int_mask), .cmd_clr_all(cmd_clr_all), .cmd_pin_rel(cmd_pin_rel),
    .cmd_soft_rst(cmd_soft_rst), .port_off(port_off), .evt_q(evt_q),
    .stat_q(stat_q), .dcen_q(dcen_q), .pe_q(pe_q), .pg_q(pg_q),
    .pec_q(pec_q), .pgc_q(pgc_q), .sup_uv_q(sup_uv_q), .int_sum(int_sum),
    .int_n(int_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, data, expected strobes {clr_all, pin_rel, soft_rst, off[3:0]}}
  localparam int NVEC = 10;
  localparam logic [22:0] VEC [NVEC] = '{
    {8'h1A, 8'h80, 7'b100_0000},
    {8'h1A, 8'h40, 7'b010_0000},
    {8'h1A, 8'h20, 7'b000_0000},
    {8'h1B, 8'hFF, 7'b000_0000},
    {8'h1A, 8'h05, 7'b000_0101},
    {8'h1A, 8'h0A, 7'b000_1010},
    {8'h1A, 8'h00, 7'b000_0000},
    {8'h19, 8'h8F, 7'b000_0000},
    {8'h1A, 8'h10, 7'b001_0000},
    {8'h1A, 8'hF0, 7'b111_0000}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {cmd_clr_all, cmd_pin_rel, cmd_soft_rst, port_off};
  endfunction

  // Returns after the edge where the model state moves; stb holds the strobes.
  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output logic [6:0] stb);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    stb = strobes();
    @(negedge clk);
  endtask

  task automatic pulse_evt(input int p, input logic [EVW-1:0] bits);
    @(negedge clk);
    evt_set[p*EVW +: EVW] = bits;
    @(negedge clk);
    evt_set = '0;
    @(negedge clk);
  endtask

  logic [6:0] stb;

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    evt_set = '0; stat_we = '0; stat_wdata = '0; dcen_we = '0; dcen_wdata = '0;
    pwr_on_req = '0; pg_live = '1; uv_live = '0; int_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R6 reset strobes", 64'(strobes()), 64'h0);
    chk("R6 reset evt_q", 64'(evt_q), 64'h0);
    chk("R6 reset pe_q", 64'(pe_q), 64'h0);
    chk("R11 reset int_n", 64'(int_n), 64'h1);

    // Decode table: R1 R2
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][22:15], VEC[i][14:7], stb);
      chk("R1 R2 strobe vector", 64'(stb), 64'(VEC[i][6:0]));
      chk("R2 one-shot strobe", 64'(strobes()), 64'h0);
    end

    // R1: right address with host_wr low
    @(negedge clk);
    host_addr = 8'h1A; host_wdata = 8'hFF;
    @(negedge clk);
    chk("R1 no write no strobe", 64'(strobes()), 64'h0);

    // R11 R12: sticky events and summary
    pulse_evt(1, 7'b000_0011);
    pulse_evt(2, 7'b000_0100);
    chk("R11 evt layout", 64'(evt_q), (64'h3 << 7) | (64'h4 << 14));
    chk("R12 summary detect+fault", 64'(int_sum), 64'b00110);
    chk("R11 pin asserted", 64'(int_n), 64'h0);
    int_mask = 5'b10001;
    @(negedge clk);
    chk("R11 masked categories", 64'(int_n), 64'h1);
    int_mask = '1;

    // R4: release pin only
    do_write(8'h1A, 8'h40, stb);
    chk("R4 pin released", 64'(int_n), 64'h1);
    chk("R4 events kept", 64'(evt_q), (64'h3 << 7) | (64'h4 << 14));
    chk("R4 summary kept", 64'(int_sum), 64'b00110);

    // R5: new unmasked event asserts again
    pulse_evt(3, 7'b001_0000);
    chk("R5 reassert on new event", 64'(int_n), 64'h0);
    chk("R12 summary start", 64'(int_sum), 64'b01110);
    do_write(8'h1A, 8'h40, stb);
    int_mask = 5'b10111;
    pulse_evt(0, 7'b010_0000);
    chk("R5 masked new event stays released", 64'(int_n), 64'h1);
    int_mask = '1;

    // R3: clear-all
    do_write(8'h1A, 8'h80, stb);
    chk("R3 events cleared", 64'(evt_q), 64'h0);
    chk("R3 summary cleared", 64'(int_sum), 64'h0);
    chk("R3 pin high", 64'(int_n), 64'h1);

    // R7 R8: port reset fan-out
    @(negedge clk); pwr_on_req = 4'b0011;
    @(negedge clk); pwr_on_req = '0;
    @(negedge clk);
    chk("R8 power on pe", 64'(pe_q), 64'h3);
    chk("R8 power on pg", 64'(pg_q), 64'h3);
    chk("R8 power on pec", 64'(pec_q), 64'h3);
    do_write(8'h1A, 8'h80, stb);
    @(negedge clk); stat_we = 4'b0001; stat_wdata = 7'h55;
    @(negedge clk); stat_we = 4'b0010; stat_wdata = 7'h2A;
    @(negedge clk); stat_we = '0; dcen_we = 4'b0011; dcen_wdata = 2'b11;
    @(negedge clk); dcen_we = '0;
    pulse_evt(0, 7'h7F);
    pulse_evt(1, 7'h7F);
    do_write(8'h1A, 8'h01, stb);
    chk("R7 port0 strobe", 64'(stb), 64'h01);
    chk("R7 events port0 only", 64'(evt_q), 64'h7F << 7);
    chk("R7 status port0 only", 64'(stat_q), 64'h2A << 7);
    chk("R7 enables port0 only", 64'(dcen_q), 64'h0C);
    chk("R7 pe", 64'(pe_q), 64'h2);
    chk("R7 pg", 64'(pg_q), 64'h2);
    chk("R8 pec on turn-off", 64'(pec_q), 64'h1);
    chk("R8 pgc on turn-off", 64'(pgc_q), 64'h1);
    do_write(8'h1A, 8'h80, stb);
    do_write(8'h1A, 8'h04, stb);
    chk("R8 no change no pec", 64'(pec_q), 64'h0);
    chk("R8 no change no pgc", 64'(pgc_q), 64'h0);

    // R9: re-power right after port reset
    @(negedge clk); pwr_on_req = 4'b0001;
    @(negedge clk);
    do_write(8'h1A, 8'h80, stb);
    do_write(8'h1A, 8'h01, stb);
    chk("R9 reset wins its edge", 64'(pe_q), 64'h2);
    @(negedge clk);
    chk("R9 powered next cycle", 64'(pe_q), 64'h3);
    pwr_on_req = '0;

    // R10: clear-all beats change flags from port reset
    do_write(8'h1A, 8'h80, stb);
    do_write(8'h1A, 8'h82, stb);
    chk("R10 pe port1 off", 64'(pe_q), 64'h1);
    chk("R10 pec suppressed", 64'(pec_q), 64'h0);
    chk("R10 pgc suppressed", 64'(pgc_q), 64'h0);

    // R6: soft reset keeps live supply flags
    uv_live = 2'b01;
    repeat (2) @(negedge clk);
    chk("R6 supply flag set", 64'(sup_uv_q), 64'h1);
    pulse_evt(2, 7'h01);
    do_write(8'h1A, 8'h10, stb);
    chk("R6 pe cleared", 64'(pe_q), 64'h0);
    chk("R6 pg cleared", 64'(pg_q), 64'h0);
    chk("R6 events cleared", 64'(evt_q), 64'h0);
    chk("R6 status cleared", 64'(stat_q), 64'h0);
    chk("R6 enables cleared", 64'(dcen_q), 64'h0);
    chk("R6 supply follows rail", 64'(sup_uv_q), 64'h1);
    chk("R6 summary supply only", 64'(int_sum), 64'b10000);
    chk("R6 supply drives pin", 64'(int_n), 64'h0);

    // R3: clear-all drops supply flags once the rail is good
    uv_live = 2'b00;
    do_write(8'h1A, 8'h80, stb);
    chk("R3 supply cleared", 64'(sup_uv_q), 64'h0);
    chk("R3 pin high after clear", 64'(int_n), 64'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule